// File: doc/BRIEF.md
# Selectable Decade/Hex Timebase Scaler

This block turns a fast reference clock into a set of slower counting rates for downstream counters. No divided clocks are generated. Every rate is a single-cycle enable strobe in the reference clock domain. A first divider brings the reference down to a base rate, which is either one tenth or one half of the reference. A chain of scaler stages then derives four further rates from it, each one a fixed ratio below its neighbour. That ratio is 10 in decade mode and 16 in hex mode.

With a 10 MHz reference and the slow base rate, the five taps run at 1 MHz, 100 kHz, 10 kHz, 1 kHz and 100 Hz in decade mode. In hex mode they run at 1 MHz, 62.5 kHz, about 3906 Hz, about 244 Hz and about 15 Hz. The fast base rate lifts every tap by a factor of five. A 3-bit selector routes one tap to a single output strobe that a counter can use as its count enable. Whenever the base rate or the scaler mode changes, the whole chain restarts from zero.

Top module: `timebaseScaler`

## Requirements
- R1: A synchronous active-high `rst` clears every stage. No tap strobe and no selected strobe is high in a cycle where `rst` is high. After release, the first tap-0 strobe comes exactly one base period after the clearing edge.
- R2: With `rateFast` = 0, tap 0 pulses once every 10 clock cycles. With `rateFast` = 1, it pulses once every 2 cycles. Each pulse is one cycle wide.
- R3: With `hexMode` = 0 (decade), tap k pulses once every base·10^k cycles. Its first pulse is at cycle base·10^k − 1, counted from the first cycle after a clear.
- R4: With `hexMode` = 1 (hex), tap k pulses once every base·16^k cycles. Its first pulse is at cycle base·16^k − 1, counted from the first cycle after a clear.
- R5: Tap k (k ≥ 1) is only ever high in a cycle where tap k−1 is also high. All taps are bits of `tapStrobe`, with bit 0 being the fastest tap.
- R6: For `tapSel` values 0 to 4, `selStrobe` equals `tapStrobe[tapSel]`. Value 0 selects the fastest tap and value 4 the slowest.
- R7: For `tapSel` values 5, 6 and 7, `selStrobe` stays low.
- R8: A change of `rateFast` or `hexMode` clears every stage synchronously, like a reset. All strobes are low in the cycle the change is first seen, and the taps afterwards follow the timing of R3/R4 from that clear.
- R9: A change of `tapSel` alone does not restart the chain. The newly selected tap keeps the phase it had before the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all strobes are enables in this domain |
| rst | input | 1 | Synchronous active-high reset of all stages |
| rateFast | input | 1 | Base rate select: 0 = reference/10, 1 = reference/2 |
| hexMode | input | 1 | Scaler ratio select: 0 = divide by 10, 1 = divide by 16 |
| tapSel | input | 3 | Tap routed to `selStrobe`; 5 to 7 select nothing |
| tapStrobe | output | 5 | One enable strobe per tap, bit 0 fastest |
| selStrobe | output | 1 | Strobe of the selected tap |

## Verification
Several properties are checked on every cycle: that tap strobes nest, that each stage fires after exactly the programmed number of lower-tap pulses, the spacing of tap 0, the routing done by the selector, and that all strobes stay quiet during reset and configuration changes. The absolute phase of each tap after a clear is exercised only by the bench's scenarios. These cover the long periods of the slow taps in both modes, a mode or rate change in the middle of a count, and a selector change that must leave the chain's phase untouched.

// File: rtl/tsPkg.sv
package tsPkg;

  // Control strobes passed from the control unit to the datapath
  typedef struct packed {
    logic clear;     // synchronous clear of every stage
    logic fastRate;  // base divider uses the short ratio
    logic hexMode;   // scaler stages use the hex ratio
  } tsCtrl_t;

endpackage

// File: rtl/tsControl.sv
module tsControl
  import tsPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rateFast,
  input  logic    hexMode,
  output tsCtrl_t ctrl
);

  logic rateQ;
  logic hexQ;
  logic cfgChange;

  // Remember the configuration seen last cycle
  always_ff @(posedge clk) begin
    rateQ <= rateFast;
    hexQ  <= hexMode;
  end

  assign cfgChange = (rateFast != rateQ) || (hexMode != hexQ);

  always_comb begin
    ctrl.clear    = rst || cfgChange;
    ctrl.fastRate = rateFast;
    ctrl.hexMode  = hexMode;
  end

endmodule

// File: rtl/tsStage.sv
module tsStage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         advance,
  input  logic [W-1:0] last,
  output logic         wrap
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= (cnt == last) ? '0 : cnt + W'(1);
    end
  end

  // One-cycle carry to the next stage; silenced during a clear
  assign wrap = advance && (cnt == last) && !clear;

endmodule

// File: rtl/tsTapMux.sv
module tsTapMux #(
  parameter int NUM_TAPS = 5,
  parameter int SEL_W    = 3
) (
  input  logic [NUM_TAPS-1:0] taps,
  input  logic [SEL_W-1:0]    tapSel,
  output logic                selStrobe
);

  always_comb begin
    selStrobe = 1'b0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      if (tapSel == SEL_W'(k)) selStrobe = taps[k];
    end
  end

endmodule

// File: rtl/tsDatapath.sv
module tsDatapath
  import tsPkg::*;
#(
  parameter int NUM_TAPS  = 5,
  parameter int SEL_W     = 3,
  parameter int SLOW_DIV  = 10,
  parameter int FAST_DIV  = 2,
  parameter int DEC_RATIO = 10,
  parameter int HEX_RATIO = 16,
  parameter int PRE_W     = 4,
  parameter int STG_W     = 4
) (
  input  logic                clk,
  input  tsCtrl_t             ctrl,
  input  logic [SEL_W-1:0]    tapSel,
  output logic [NUM_TAPS-1:0] tapStrobe,
  output logic                selStrobe
);

  logic [PRE_W-1:0] preLast;
  logic [STG_W-1:0] stgLast;
  logic [NUM_TAPS-1:0] taps;

  assign preLast = ctrl.fastRate ? PRE_W'(FAST_DIV - 1) : PRE_W'(SLOW_DIV - 1);
  assign stgLast = ctrl.hexMode  ? STG_W'(HEX_RATIO - 1) : STG_W'(DEC_RATIO - 1);

  // Base-rate divider: advances on every reference cycle
  tsStage #(.W(PRE_W)) i_base (
    .clk     (clk),
    .clear   (ctrl.clear),
    .advance (1'b1),
    .last    (preLast),
    .wrap    (taps[0])
  );

  // Scaler chain: each stage counts carries of the one below
  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_chain
    tsStage #(.W(STG_W)) i_stage (
      .clk     (clk),
      .clear   (ctrl.clear),
      .advance (taps[k-1]),
      .last    (stgLast),
      .wrap    (taps[k])
    );
  end

  tsTapMux #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) i_mux (
    .taps      (taps),
    .tapSel    (tapSel),
    .selStrobe (selStrobe)
  );

  assign tapStrobe = taps;

endmodule

// File: rtl/timebaseScaler.sv
module timebaseScaler
  import tsPkg::*;
#(
  parameter int NUM_TAPS  = 5,
  parameter int SEL_W     = 3,
  parameter int SLOW_DIV  = 10,
  parameter int FAST_DIV  = 2,
  parameter int DEC_RATIO = 10,
  parameter int HEX_RATIO = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rateFast,
  input  logic                hexMode,
  input  logic [SEL_W-1:0]    tapSel,
  output logic [NUM_TAPS-1:0] tapStrobe,
  output logic                selStrobe
);

  localparam int MAX_DIV   = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int MAX_RATIO = (HEX_RATIO > DEC_RATIO) ? HEX_RATIO : DEC_RATIO;
  localparam int PRE_W     = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam int STG_W     = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;

  tsCtrl_t ctrl;

  tsControl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rateFast (rateFast),
    .hexMode  (hexMode),
    .ctrl     (ctrl)
  );

  tsDatapath #(
    .NUM_TAPS  (NUM_TAPS),
    .SEL_W     (SEL_W),
    .SLOW_DIV  (SLOW_DIV),
    .FAST_DIV  (FAST_DIV),
    .DEC_RATIO (DEC_RATIO),
    .HEX_RATIO (HEX_RATIO),
    .PRE_W     (PRE_W),
    .STG_W     (STG_W)
  ) i_dp (
    .clk       (clk),
    .ctrl      (ctrl),
    .tapSel    (tapSel),
    .tapStrobe (tapStrobe),
    .selStrobe (selStrobe)
  );

endmodule

// File: rtl/tsChecker.sv
module tsChecker #(
  parameter int NUM_TAPS  = 5,
  parameter int SEL_W     = 3,
  parameter int SLOW_DIV  = 10,
  parameter int FAST_DIV  = 2,
  parameter int DEC_RATIO = 10,
  parameter int HEX_RATIO = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                rateFast,
  input logic                hexMode,
  input logic [SEL_W-1:0]    tapSel,
  input logic [NUM_TAPS-1:0] tapStrobe,
  input logic                selStrobe
);

  logic rateSeen;
  logic hexSeen;
  logic restart;
  int   gap;

  always_ff @(posedge clk) begin
    rateSeen <= rateFast;
    hexSeen  <= hexMode;
  end

  assign restart = rst || (rateFast != rateSeen) || (hexMode != hexSeen);

  // Cycles since the last tap-0 strobe or clear
  always_ff @(posedge clk) begin
    if (restart || tapStrobe[0]) gap <= 0;
    else                         gap <= gap + 1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> (tapStrobe == '0 && !selStrobe)); // R1

  AST_BASE_SPACING: assert property (@(posedge clk) disable iff (restart)
    tapStrobe[0] |-> (gap == (rateFast ? FAST_DIV - 1 : SLOW_DIV - 1))); // R2

  AST_BASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tapStrobe[0] |=> !tapStrobe[0]); // R2

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_stage
    int lowCount;
    always_ff @(posedge clk) begin
      if (restart || tapStrobe[k]) lowCount <= 0;
      else if (tapStrobe[k-1])     lowCount <= lowCount + 1;
    end

    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (rst)
      tapStrobe[k] |-> tapStrobe[k-1]); // R5

    AST_STAGE_DEC: assert property (@(posedge clk) disable iff (restart)
      (tapStrobe[k] && !hexMode) |-> (lowCount == DEC_RATIO - 1)); // R3

    AST_STAGE_HEX: assert property (@(posedge clk) disable iff (restart)
      (tapStrobe[k] && hexMode) |-> (lowCount == HEX_RATIO - 1)); // R4
  end

  AST_SEL_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (int'(tapSel) < NUM_TAPS) |-> (selStrobe == tapStrobe[tapSel])); // R6

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (int'(tapSel) >= NUM_TAPS) |-> !selStrobe); // R7

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rateFast != $past(rateFast) || hexMode != $past(hexMode)) |-> (tapStrobe == '0)); // R8

endmodule

bind timebaseScaler tsChecker #(
  .NUM_TAPS  (NUM_TAPS),
  .SEL_W     (SEL_W),
  .SLOW_DIV  (SLOW_DIV),
  .FAST_DIV  (FAST_DIV),
  .DEC_RATIO (DEC_RATIO),
  .HEX_RATIO (HEX_RATIO)
) i_tsChecker (
  .clk       (clk),
  .rst       (rst),
  .rateFast  (rateFast),
  .hexMode   (hexMode),
  .tapSel    (tapSel),
  .tapStrobe (tapStrobe),
  .selStrobe (selStrobe)
);

// File: tb/test_timebaseScaler.sv
module test_timebaseScaler;

  logic       clk = 1'b0;
  logic       rst;
  logic       rateFast;
  logic       hexMode;
  logic [2:0] tapSel;
  logic [4:0] tapStrobe;
  logic       selStrobe;

  int checkCount = 0;
  int failCount  = 0;
  int negCount   = 0;
  int origin     = 0;
  logic curFast  = 1'b0;
  logic curHex   = 1'b0;

  int    expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  timebaseScaler i_timebaseScaler (
    .clk       (clk),
    .rst       (rst),
    .rateFast  (rateFast),
    .hexMode   (hexMode),
    .tapSel    (tapSel),
    .tapStrobe (tapStrobe),
    .selStrobe (selStrobe)
  );

  // Monitor: every selected strobe must match the head of the queue
  always @(negedge clk) begin
    negCount = negCount + 1;
    if (selStrobe === 1'b1) begin
      checkCount++;
      if (expQ.size() == 0) begin
        failCount++;
        $display("FAIL unexpected strobe (R7/R8): actual cycle %0d, expected none", negCount);
      end else begin
        int    expAt;
        string tag;
        expAt = expQ.pop_front();
        tag   = tagQ.pop_front();
        if (expAt != negCount) begin
          failCount++;
          $display("FAIL %s: strobe at cycle %0d, expected cycle %0d", tag, negCount, expAt);
        end
      end
    end
  end

  function automatic int tapPeriod(input logic fast, input logic hex, input int sel);
    int p;
    p = fast ? 2 : 10;
    for (int k = 0; k < sel; k++) p = p * (hex ? 16 : 10);
    return p;
  endfunction

  // Driver: apply a configuration at negedge+1, queue expected strobes, run
  task automatic runCase(input logic useRst, input logic fast, input logic hex,
                         input logic [2:0] sel, input int runLen, input string tag);
    int startAbs;
    int period;
    logic restart;
    restart  = useRst || (fast != curFast) || (hex != curHex);
    startAbs = negCount + 1;
    if (restart) origin = startAbs;
    curFast  = fast;
    curHex   = hex;
    rateFast = fast;
    hexMode  = hex;
    tapSel   = sel;
    rst      = useRst;
    if (sel < 3'd5) begin
      period = tapPeriod(fast, hex, int'(sel));
      for (int t = startAbs - origin; t < startAbs - origin + runLen; t++) begin
        if ((t + 1) % period == 0) begin
          expQ.push_back(origin + t);
          tagQ.push_back(tag);
        end
      end
    end
    @(negedge clk);
    if (useRst) begin
      checkCount++;
      if (tapStrobe !== 5'b0 || selStrobe !== 1'b0) begin
        failCount++;
        $display("FAIL R1: strobes during reset actual %b/%b, expected 00000/0", tapStrobe, selStrobe);
      end
    end
    #1;
    rst = 1'b0;
    repeat (runLen - 1) @(negedge clk);
    #1;
    checkCount++;
    if (expQ.size() != 0) begin
      failCount++;
      $display("FAIL %s: %0d strobes missing, expected 0 missing", tag, expQ.size());
      expQ.delete();
      tagQ.delete();
    end
  endtask

  initial begin
    #1500000;
    failCount++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    rst = 1'b1; rateFast = 1'b0; hexMode = 1'b0; tapSel = 3'd0;
    repeat (3) @(negedge clk);
    #1;
    checkCount++;
    if (tapStrobe !== 5'b0) begin
      failCount++;
      $display("FAIL R1: reset state actual %b, expected 00000", tapStrobe);
    end
    runCase(1'b1, 1'b0, 1'b0, 3'd0, 100,   "R1 R2 slow base tap0");
    runCase(1'b1, 1'b0, 1'b0, 3'd2, 3000,  "R3 decade tap2 slow");
    runCase(1'b1, 1'b1, 1'b0, 3'd4, 40001, "R3 decade tap4 fast");
    runCase(1'b1, 1'b1, 1'b1, 3'd1, 200,   "R2 R4 hex tap1 fast");
    runCase(1'b1, 1'b0, 1'b1, 3'd3, 41000, "R4 hex tap3 slow");
    runCase(1'b1, 1'b1, 1'b1, 3'd3, 16400, "R4 hex tap3 fast");
    runCase(1'b1, 1'b1, 1'b0, 3'd5, 200,   "R7 sel5");
    runCase(1'b0, 1'b1, 1'b0, 3'd6, 200,   "R7 sel6");
    runCase(1'b0, 1'b1, 1'b0, 3'd7, 200,   "R7 sel7");
    // R9: selector change keeps the chain phase
    runCase(1'b1, 1'b0, 1'b0, 3'd0, 55,    "R9 before sel change");
    runCase(1'b0, 1'b0, 1'b0, 3'd1, 250,   "R9 after sel change");
    // R8: mode and rate changes mid-count restart the chain
    runCase(1'b1, 1'b0, 1'b0, 3'd1, 150,   "R8 decade lead-in");
    runCase(1'b0, 1'b0, 1'b1, 3'd1, 200,   "R8 after mode change");
    runCase(1'b0, 1'b1, 1'b1, 3'd1, 70,    "R8 after rate change");
    runCase(1'b0, 1'b1, 1'b0, 3'd0, 30,    "R5 R8 back to decade");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule